// File: doc/BRIEF.md
# Edge-Latched Single-Bit Static Memory

This block models a 1024-word by 1-bit static memory run from two active-low strobes: a chip enable and a write enable. A fast system clock samples both strobes, and the address and data-in, through a short aligning pipeline. The memory captures its address only at the moment the enable is seen to fall. After that, the address pins may wander freely until the next falling edge. Reads return the latched location on a single data pin. A separate output-enable flag marks the cycles in which a real bus driver would be active, and so stands in for a tri-state buffer.

A write portion exists whenever enable and write enable are both low. It is committed on whichever of the two strobes rises first, using the data present at that rising edge. Write enable may stay low across a run of enable pulses, so that every pulse stores to its own latched address. Write enable may also pulse low inside an enable-low period that is already reading, so that the location is read, then rewritten one or more times. The output comes on a set number of cycles after the enable falls. Valid data follows a set number of cycles later still, and the data pin holds 0 in between.

Top module: `latched_bit_sram`

## Requirements
- R1: While and just after reset, `dout_oe` is 0 and `dout` is 0.
- R2: The address stored for an access is the value on `addr` when the internal view of `en_n` first shows low. Changes to `addr` after that point do not change which location is read or written until the next falling edge.
- R3: While the internal view of `en_n` is high, `dout_oe` is 0. Pulses of `wr_n` in that time store nothing.
- R4: With `wr_n` high, `dout_oe` goes to 1 exactly `SYNC_STAGES + OE_DELAY` clocks after `en_n` is driven low, and valid data appears `SYNC_STAGES + VALID_DELAY` clocks after it. `dout` is 0 whenever data is not valid, and every strobe reaches the internal view `SYNC_STAGES` clocks after the pins.
- R5: A write is committed when enable or write enable rises after a cycle in which both were low. The stored bit is the `din` value that travels with that rising edge. Later changes of `din` are ignored.
- R6: `dout_oe` is 0 in every cycle in which the internal view of `wr_n` is low.
- R7: With `wr_n` held low across several enable pulses, each pulse stores its own `din` into its own latched address when the enable rises.
- R8: When write enable pulses low and returns high during a read, the new bit is stored on its rise. From that same cycle on, `dout` shows the new bit. The location may be rewritten again before the enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low chip enable; its falling edge latches the address |
| wr_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Word address (10 bits by default) |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit; 0 unless valid |
| dout_oe | output | 1 | High when the data output would be driven |

## Verification
A stale latched address shows up at the ports as a read of the wrong word. It appears in the first valid-data cycle of the next access, and every read-back uses a disturbed address pin so that this cannot be hidden. A commit that fires on the wrong edge, or takes the wrong data, stays hidden until that location is read again. For this reason the reads follow the writes closely, and the combined cycle checks the output in the very cycle of the write-enable rise. A miscounted delay shows within one clock as a wrong `dout_oe` or a nonzero `dout`, because a reference model compares both outputs on every clock.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  // True once a cycle count has reached a programmed delay.
  function automatic logic reached(input int unsigned count, input int unsigned limit);
    return count >= limit;
  endfunction

  // Count that climbs by one and stops at its limit.
  function automatic int unsigned sat_step(input int unsigned count, input int unsigned limit);
    return (count >= limit) ? limit : count + 1;
  endfunction
endpackage

// File: rtl/lbs_sync.sv
module lbs_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_ONE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] RST_VAL = {WIDTH{RST_ONE}};

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else if (g == 0) stage[g] <= d;
      else stage[g] <= stage[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int OE_DELAY    = 2,
  parameter int VALID_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_s,
  input  logic              w_s,
  input  logic [ADDR_W-1:0] a_s,
  output logic              e_fall,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              oe,
  output logic              data_valid
);
  localparam int CNT_W = $clog2(VALID_DELAY + 1);

  logic             e_q, w_q;
  logic [CNT_W-1:0] cnt;
  logic             e_rise, w_rise, wr_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_q <= 1'b1;
      w_q <= 1'b1;
    end else begin
      e_q <= e_s;
      w_q <= w_s;
    end
  end

  assign e_fall    = e_q & ~e_s;
  assign e_rise    = ~e_q & e_s;
  assign w_rise    = ~w_q & w_s;
  assign wr_window = ~e_q & ~w_q;
  assign wr_commit = wr_window & (e_rise | w_rise);

  always_ff @(posedge clk) begin
    if (!rst_n) lat_addr <= '0;
    else if (e_fall) lat_addr <= a_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || e_s) cnt <= '0;
    else cnt <= CNT_W'(lbs_pkg::sat_step(int'(cnt), VALID_DELAY));
  end

  assign oe         = ~e_s & w_s & lbs_pkg::reached(int'(cnt), OE_DELAY);
  assign data_valid = oe & lbs_pkg::reached(int'(cnt), VALID_DELAY);
endmodule

// File: rtl/lbs_array.sv
module lbs_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic              rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/latched_bit_sram.sv
module latched_bit_sram #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int OE_DELAY    = 2,
  parameter int VALID_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe
);
  localparam int DAT_W = ADDR_W + 1;

  logic [1:0]        ctl_s;
  logic [DAT_W-1:0]  dat_s;
  logic              e_s, w_s, d_s;
  logic [ADDR_W-1:0] a_s;
  logic              e_fall, wr_commit, data_valid, rdata;
  logic [ADDR_W-1:0] lat_addr;

  lbs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({en_n, wr_n}), .q(ctl_s)
  );

  lbs_sync #(.WIDTH(DAT_W), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(dat_s)
  );

  assign e_s = ctl_s[1];
  assign w_s = ctl_s[0];
  assign a_s = dat_s[DAT_W-1:1];
  assign d_s = dat_s[0];

  lbs_ctrl #(.ADDR_W(ADDR_W), .OE_DELAY(OE_DELAY), .VALID_DELAY(VALID_DELAY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .e_s(e_s), .w_s(w_s), .a_s(a_s),
    .e_fall(e_fall), .wr_commit(wr_commit), .lat_addr(lat_addr),
    .oe(dout_oe), .data_valid(data_valid)
  );

  lbs_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(wr_commit), .addr(lat_addr), .wdata(d_s), .rdata(rdata)
  );

  // A write-enable rise during a read shows the new bit in its own cycle.
  assign dout = data_valid ? (wr_commit ? d_s : rdata) : 1'b0;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              e_s,
  input logic              w_s,
  input logic [ADDR_W-1:0] a_s,
  input logic              e_fall,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] lat_addr,
  input logic              dout,
  input logic              dout_oe
);
  p_idle_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
    e_s |-> !dout_oe);

  p_write_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !w_s |-> !dout_oe);

  p_dout_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  p_no_instant_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_s) |-> !dout_oe);

  p_addr_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    e_fall |=> lat_addr == $past(a_s));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !e_fall |=> $stable(lat_addr));

  p_commit_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!$past(e_s) && !$past(w_s) && (e_s || w_s)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!dout_oe && !dout));
endmodule

bind latched_bit_sram lbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .e_s(e_s), .w_s(w_s), .a_s(a_s),
  .e_fall(e_fall), .wr_commit(wr_commit), .lat_addr(lat_addr),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_latched_bit_sram.sv
module test_latched_bit_sram;
  localparam int AW = 10;
  localparam int S  = 2;
  localparam int OE = 2;
  localparam int VD = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1, wr_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  latched_bit_sram #(.ADDR_W(AW), .SYNC_STAGES(S), .OE_DELAY(OE), .VALID_DELAY(VD)) i_latched_bit_sram (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .wr_n(wr_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: pin history, latched word, counter, written cells.
  int        h_e [S+1];
  int        h_w [S+1];
  int        h_a [S+1];
  int        h_d [S+1];
  bit        m_mem   [DEPTH];
  bit        m_known [DEPTH];
  int        m_lat = 0;
  int        m_cnt = 0;

  function automatic bit m_commit();
    int e = h_e[S-1], eq = h_e[S], w = h_w[S-1], wq = h_w[S];
    return (eq == 0 && wq == 0) && ((e == 1) || (w == 1));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= S; i++) begin
        h_e[i] = 1; h_w[i] = 1; h_a[i] = 0; h_d[i] = 0;
      end
      m_lat = 0; m_cnt = 0;
    end else begin
      if (h_e[S] == 1 && h_e[S-1] == 0) m_lat = h_a[S-1];
      if (m_commit()) begin
        m_mem[m_lat] = h_d[S-1] != 0;
        m_known[m_lat] = 1'b1;
      end
      if (h_e[S-1] == 1) m_cnt = 0;
      else if (m_cnt < VD) m_cnt++;
      for (int i = S; i > 0; i--) begin
        h_e[i] = h_e[i-1]; h_w[i] = h_w[i-1]; h_a[i] = h_a[i-1]; h_d[i] = h_d[i-1];
      end
      h_e[0] = int'(en_n); h_w[0] = int'(wr_n); h_a[0] = int'(addr); h_d[0] = int'(din);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit x_oe, x_valid, x_d, known_ok;
      x_oe    = (h_e[S-1] == 0) && (h_w[S-1] == 1) && (m_cnt >= OE);
      x_valid = x_oe && (m_cnt >= VD);
      known_ok = !x_valid || m_commit() || m_known[m_lat];
      x_d = x_valid ? (m_commit() ? (h_d[S-1] != 0) : m_mem[m_lat]) : 1'b0;
      chk("R4 model dout_oe", dout_oe, x_oe);
      if (known_ok) chk("R4 model dout", dout, x_d);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic d);
    en_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    tick(3);
    en_n = 1'b1; wr_n = 1'b1;
    tick(3);
  endtask

  // Read with the address pin disturbed right after the fall (R2).
  task automatic read_chk(input logic [AW-1:0] a, input logic exp, input string tag);
    en_n = 1'b0; wr_n = 1'b1; addr = a;
    tick(1);
    addr = ~a;
    tick(S + VD - 1);
    chk({tag, " oe"}, dout_oe, 1'b1);
    chk({tag, " data"}, dout, exp);
    en_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    chk("R1 oe in reset", dout_oe, 1'b0);
    chk("R1 dout in reset", dout, 1'b0);
    rst_n = 1'b1;
    tick(2);
    chk("R1 oe after reset", dout_oe, 1'b0);
    chk("R1 dout after reset", dout, 1'b0);

    // R5 basic writes and reads across patterns and the address ends.
    do_write(10'd0, 1'b1);
    do_write(10'd1023, 1'b1);
    do_write(10'h155, 1'b0);
    do_write(10'h2AA, 1'b1);
    read_chk(10'd0, 1'b1, "R5 addr0");
    read_chk(10'd1023, 1'b1, "R5 addr1023");
    read_chk(10'h155, 1'b0, "R2 addr155");
    read_chk(10'h2AA, 1'b1, "R2 addr2AA");
    for (int i = 0; i < 24; i++) do_write(AW'(i * 37 + 5), 1'((i ^ (i >> 2)) & 1));
    for (int i = 0; i < 24; i++) read_chk(AW'(i * 37 + 5), 1'((i ^ (i >> 2)) & 1), "R5 sweep");

    // R4 output timing counted from the pin edge.
    en_n = 1'b0; wr_n = 1'b1; addr = 10'd1023;
    tick(S + OE - 1);
    chk("R4 oe not yet", dout_oe, 1'b0);
    tick(1);
    chk("R4 oe on time", dout_oe, 1'b1);
    chk("R4 zero before valid", dout, 1'b0);
    tick(VD - OE - 1);
    chk("R4 still zero", dout, 1'b0);
    tick(1);
    chk("R4 valid on time", dout, 1'b1);

    // R6 write enable mutes the output.
    wr_n = 1'b0; din = 1'b1;
    tick(S);
    chk("R6 oe off", dout_oe, 1'b0);
    wr_n = 1'b1; en_n = 1'b1;
    tick(4);

    // R3 write pulses with enable high store nothing.
    do_write(10'h0F0, 1'b1);
    wr_n = 1'b0; addr = 10'h0F0; din = 1'b0;
    tick(3);
    chk("R3 oe idle", dout_oe, 1'b0);
    wr_n = 1'b1;
    tick(3);
    chk("R3 dout idle", dout, 1'b0);
    read_chk(10'h0F0, 1'b1, "R3 untouched");

    // R7 write enable held low across enable pulses.
    wr_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      en_n = 1'b0; addr = AW'(10'h300 + i); din = 1'(i & 1);
      tick(3);
      en_n = 1'b1;
      tick(2);
    end
    wr_n = 1'b1;
    tick(2);
    for (int i = 0; i < 4; i++) read_chk(AW'(10'h300 + i), 1'(i & 1), "R7 burst");

    // R8 read, then rewrite twice in one enable-low period.
    do_write(10'h044, 1'b0);
    en_n = 1'b0; wr_n = 1'b1; addr = 10'h044;
    tick(S + VD);
    chk("R8 first read", dout, 1'b0);
    wr_n = 1'b0; din = 1'b1;
    tick(3);
    chk("R6 oe off in rmw", dout_oe, 1'b0);
    wr_n = 1'b1;
    tick(S);
    chk("R8 oe back", dout_oe, 1'b1);
    chk("R8 new bit same cycle", dout, 1'b1);
    tick(1);
    chk("R8 new bit held", dout, 1'b1);
    wr_n = 1'b0; din = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(3);
    chk("R8 second rewrite", dout, 1'b0);
    en_n = 1'b1;
    tick(3);
    read_chk(10'h044, 1'b0, "R8 final");

    // R5 data taken at the write-enable rise, later din ignored.
    en_n = 1'b0; wr_n = 1'b0; addr = 10'h123; din = 1'b1;
    tick(3);
    wr_n = 1'b1;
    tick(1);
    din = 1'b0;
    tick(3);
    en_n = 1'b1;
    tick(3);
    read_chk(10'h123, 1'b1, "R5 w-rise data");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule